// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a small bus-attached timer. It holds a 16-bit down-counter, a 16-bit reload register and a 32-bit control word, all reachable through a word-wide register port inside a 256-byte window. Software writes a reload value, and that value is also copied into the live counter at once. Software then sets the start bit in the control word. From then on the counter steps down by one on every cycle in which the tick-enable input is high. The tick-enable input is a one-cycle strobe at the fixed 1 MHz rate, derived elsewhere from the system clock.

When a running counter sits at zero, the next tick reloads it from the reload register, so counting is periodic. A clear bit in the control word returns the whole block to its idle state. The clear bit takes priority over every other bit written in the same word. The start bit only starts the counter: writing a control word with the start bit low leaves a running counter running. Reads and writes on the bus complete in one cycle. Read data is combinational from the current register state, and a write takes effect at the clock edge that samples it.

Top module: `prt_timer`

## Requirements
- R1: After the synchronous active-high reset `rst`, the control, reload and count registers all read zero and the counter is stopped, so ticks leave the count unchanged until a start.
- R2: Only word-aligned accesses decode: control sits at byte offset 0x00, reload at 0x04 and count at 0x08. A read of any other offset, or of an address with bits 1:0 nonzero, returns zero. A write to such an address changes no register. With `bus_sel` low, `bus_rdata` is zero.
- R3: A control write with bit 1 (clear) set stops the counter and sets control, reload and count to zero. The rest of that word is discarded, even if bit 0 is also set.
- R4: A control write with bit 0 (start) set and bit 1 clear starts the counter, and the full 32-bit word is stored and read back unchanged.
- R5: A control write with bit 1 and bit 0 both clear stores the word but does not stop a counter that is already running.
- R6: A reload write keeps only bits 15:0. That value reads back from the reload register, zero-extended, and is loaded into the count in the same clock edge, whether or not the counter runs.
- R7: While running, each cycle with `tick_en` high lowers a nonzero count by one. Cycles without `tick_en` leave the count unchanged.
- R8: While running, a tick that finds the count at zero loads it from the reload register. With a reload of zero the count stays at zero.
- R9: Reading the count register returns the 16-bit count zero-extended to 32 bits. Writes to the count offset have no effect.
- R10: While stopped, `tick_en` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count strobe at the 1 MHz rate |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading a decoded register |

## Verification
The bench builds the block with its default parameters: 32-bit data, an 8-bit byte address and a 16-bit count. With those widths, reload writes that carry ones in bits 31:16 show that the upper half is masked, and an address window of 256 bytes lets unaligned and unmapped offsets be probed on both sides of the three registers. A short reload of three brings the zero-crossing reload within a few ticks. That same sequence also covers start-only enable, clear-over-start priority and reload-while-running.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int unsigned CTRL_START_BIT = 0;
    localparam int unsigned CTRL_CLEAR_BIT = 1;

    typedef enum logic [1:0] {
        RSEL_CTRL   = 2'd0,
        RSEL_RELOAD = 2'd1,
        RSEL_COUNT  = 2'd2,
        RSEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic clear;
        logic start;
        logic load;
    } cnt_cmd_t;

    // word-aligned decode of a byte address
    function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
        reg_sel_e sel;
        if (byte_addr[1:0] != 2'b00) begin
            sel = RSEL_NONE;
        end else begin
            case (byte_addr[31:2])
                30'd0:   sel = RSEL_CTRL;
                30'd1:   sel = RSEL_RELOAD;
                30'd2:   sel = RSEL_COUNT;
                default: sel = RSEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/prt_regbank.sv
module prt_regbank
    import prt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_value,
    output logic [DATA_W-1:0] bus_rdata,
    output cnt_cmd_t          cmd,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  reload_q,
    output logic [DATA_W-1:0] ctrl_q
);

    reg_sel_e rsel;
    logic     wr_acc;
    logic     rd_acc;

    always_comb begin
        rsel   = decode_addr(32'(bus_addr));
        wr_acc = bus_sel && bus_we;
        rd_acc = bus_sel && !bus_we;
    end

    always_comb begin
        cmd.clear = wr_acc && (rsel == RSEL_CTRL) && bus_wdata[CTRL_CLEAR_BIT];
        cmd.start = wr_acc && (rsel == RSEL_CTRL) && !bus_wdata[CTRL_CLEAR_BIT]
                    && bus_wdata[CTRL_START_BIT];
        cmd.load  = wr_acc && (rsel == RSEL_RELOAD);
        load_val  = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else begin
            if (wr_acc && (rsel == RSEL_CTRL)) begin
                ctrl_q <= bus_wdata;
            end
            if (cmd.load) begin
                reload_q <= load_val;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (rsel)
                RSEL_CTRL:   bus_rdata = ctrl_q;
                RSEL_RELOAD: bus_rdata = DATA_W'(reload_q);
                RSEL_COUNT:  bus_rdata = DATA_W'(cnt_value);
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prt_counter.sv
module prt_counter
    import prt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  cnt_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output logic             run_q
);

    logic [CNT_W-1:0] next_step;

    always_comb begin
        if (count_q == '0) begin
            next_step = reload_q;
        end else begin
            next_step = count_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else begin
            if (cmd.start) begin
                run_q <= 1'b1;
            end
            if (cmd.load) begin
                count_q <= load_val;
            end else if (run_q && tick_en) begin
                count_q <= next_step;
            end
        end
    end

endmodule

// File: rtl/prt_timer.sv
module prt_timer
    import prt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    cnt_cmd_t          cmd;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              run_q;

    prt_regbank #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cnt_value(count_q),
        .bus_rdata(bus_rdata),
        .cmd      (cmd),
        .load_val (load_val),
        .reload_q (reload_q),
        .ctrl_q   (ctrl_q)
    );

    prt_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cmd     (cmd),
        .load_val(load_val),
        .reload_q(reload_q),
        .count_q (count_q),
        .run_q   (run_q)
    );

endmodule

// File: rtl/prt_timer_sva.sv
module prt_timer_sva #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              run_q
);

    logic any_wr;
    logic ctrl_wr;
    logic reload_wr;

    always_comb begin
        any_wr    = bus_sel && bus_we;
        ctrl_wr   = any_wr && (32'(bus_addr) == 32'h0);
        reload_wr = any_wr && (32'(bus_addr) == 32'h4);
    end

    // R3: clear bit empties the block
    a_r3_clear_idles: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[1]) |=> (ctrl_q == '0 && reload_q == '0 && count_q == '0 && !run_q));

    // R4: start stores the word and runs
    a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[1] && bus_wdata[0]) |=> (run_q && ctrl_q == $past(bus_wdata)));

    // R5: running stays running unless cleared
    a_r5_run_sticky: assert property (@(posedge clk) disable iff (rst)
        (run_q && !(ctrl_wr && bus_wdata[1])) |=> run_q);

    // R6: reload write lands in both registers
    a_r6_reload_loads: assert property (@(posedge clk) disable iff (rst)
        reload_wr |=> (count_q == $past(bus_wdata[CNT_W-1:0]) && reload_q == count_q));

    // R7: running tick decrements a nonzero count
    a_r7_decrement: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick_en && count_q != '0 && !any_wr) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R8: running tick at zero reloads
    a_r8_wrap_reload: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick_en && count_q == '0 && !any_wr) |=> (count_q == $past(reload_q)));

    // R10: stopped counter holds without writes
    a_r10_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !any_wr) |=> $stable(count_q));

    // R2: no read, no data
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata == '0));

endmodule

bind prt_timer prt_timer_sva #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) sva_i (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .count_q  (count_q),
    .reload_q (reload_q),
    .ctrl_q   (ctrl_q),
    .run_q    (run_q)
);

// File: tb/prt_timer_tb_top.sv
`timescale 1ns/1ps
module prt_timer_tb_top;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned CNT_W  = 16;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_RELOAD = 8'h04;
    localparam logic [7:0] A_COUNT  = 8'h08;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prt_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, bus_rdata, exp);
        end
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        expect_read(A_CTRL, 32'h0, "R1");
        expect_read(A_RELOAD, 32'h0, "R1");
        expect_read(A_COUNT, 32'h0, "R1");
    endtask

    task automatic t_reload_mask();
        bus_write(A_RELOAD, 32'h0000_1234);
        expect_read(A_RELOAD, 32'h0000_1234, "R6");
        expect_read(A_COUNT, 32'h0000_1234, "R6");
        bus_write(A_RELOAD, 32'hDEAD_5678);
        expect_read(A_RELOAD, 32'h0000_5678, "R6");
        expect_read(A_COUNT, 32'h0000_5678, "R9");
    endtask

    task automatic t_unmapped();
        expect_read(8'h0C, 32'h0, "R2");
        expect_read(8'hFC, 32'h0, "R2");
        expect_read(8'h01, 32'h0, "R2");
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'h0000_FFFF);
        bus_write(8'h02, 32'h0000_0001);
        expect_read(A_CTRL, 32'h0, "R2");
        expect_read(A_RELOAD, 32'h0000_5678, "R2");
        expect_read(A_COUNT, 32'h0000_5678, "R2");
    endtask

    task automatic t_stopped_and_count_write();
        ticks(5);
        expect_read(A_COUNT, 32'h0000_5678, "R10");
        bus_write(A_COUNT, 32'h0000_0000);
        expect_read(A_COUNT, 32'h0000_5678, "R9");
    endtask

    task automatic t_run_and_wrap();
        bus_write(A_RELOAD, 32'h0000_0003);
        bus_write(A_CTRL, 32'h0000_00F1);
        expect_read(A_CTRL, 32'h0000_00F1, "R4");
        ticks(1);
        expect_read(A_COUNT, 32'h2, "R7");
        repeat (4) @(negedge clk);
        expect_read(A_COUNT, 32'h2, "R7");
        ticks(2);
        expect_read(A_COUNT, 32'h0, "R7");
        ticks(1);
        expect_read(A_COUNT, 32'h3, "R8");
        ticks(1);
        expect_read(A_COUNT, 32'h2, "R8");
    endtask

    task automatic t_start_only();
        bus_write(A_CTRL, 32'h0000_0010);
        expect_read(A_CTRL, 32'h0000_0010, "R5");
        ticks(1);
        expect_read(A_COUNT, 32'h1, "R5");
    endtask

    task automatic t_reload_running();
        bus_write(A_RELOAD, 32'h0000_0100);
        expect_read(A_COUNT, 32'h100, "R6");
        ticks(1);
        expect_read(A_COUNT, 32'hFF, "R6");
    endtask

    task automatic t_clear();
        bus_write(A_CTRL, 32'h8000_0003);
        expect_read(A_CTRL, 32'h0, "R3");
        expect_read(A_RELOAD, 32'h0, "R3");
        expect_read(A_COUNT, 32'h0, "R3");
        bus_write(A_RELOAD, 32'h0000_0005);
        ticks(3);
        expect_read(A_COUNT, 32'h5, "R3");
    endtask

    task automatic t_zero_reload();
        bus_write(A_CTRL, 32'h0000_0001);
        bus_write(A_RELOAD, 32'h0000_0000);
        ticks(3);
        expect_read(A_COUNT, 32'h0, "R8");
    endtask

    task automatic t_hw_reset();
        bus_write(A_RELOAD, 32'h0000_0007);
        ticks(1);
        expect_read(A_COUNT, 32'h6, "R7");
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        bus_write(A_RELOAD, 32'h0000_0004);
        ticks(2);
        expect_read(A_COUNT, 32'h4, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_reload_mask();
        t_unmapped();
        t_stopped_and_count_write();
        t_run_and_wrap();
        t_start_only();
        t_reload_running();
        t_clear();
        t_zero_reload();
        t_hw_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule